// File: doc/BRIEF.md
# Bus-Master DMA Control and Status Registers

This block holds the bus-master DMA registers of a two-channel disk controller. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor table pointer. A host port reads and writes them by byte address. Writes have side effects. Turning the command run bit on or off sends a one-cycle start or abort pulse to a DMA engine, and the engine receives the channel's descriptor pointer with the start pulse.

The DMA engine reports the end of a transfer with a one-cycle completion pulse on each channel. The pulse stops the channel and raises its interrupt status bit. The interrupt output is the OR of the interrupt bits of all channels. Software clears a status bit by writing a one to it.

The port checks the size of every write. A write of the wrong size has no effect and sets a sticky error flag, which only a reset clears.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command and pointer registers of every channel read 0, every status register reads 0x60, and `irq` and `size_err` are 0.
- R2: A byte write that takes command bit 0 (run) from 0 to 1 does three things, all visible from the clock edge that takes the write: it sets status bit 0 (active), it raises that channel's `dma_start` bit for one cycle, and it leaves the channel's pointer on its `dma_ptr` slice.
- R3: A command write that takes the run bit from 1 to 0 clears the active bit and raises that channel's `dma_abort` bit for one cycle. A command write that does not change the run bit produces no pulse.
- R4: While the run bit is already 1, a command write keeps the old value of command bit 3 (direction). This holds for a write that also clears the run bit. While the channel is stopped, a write may change the direction bit.
- R5: A status write never changes status bit 0 (active). Status bits 7 to 3 store the written value.
- R6: Writing 1 to status bit 2 (interrupt) or status bit 1 (error) clears that bit. Writing 0 to either bit leaves it unchanged.
- R7: A `dma_done` pulse on a channel clears its run bit and its active bit and sets its interrupt bit. If a write to that channel arrives in the same cycle, the completion takes priority over the write's effect on those bits.
- R8: A write to a pointer register must use size code 2 (32 bits), and the register stores bits 1:0 as zero. Command and status writes must use size code 0 (byte). A write of any other size to these registers is ignored and sets `size_err`, which stays at 1 until reset.
- R9: `irq` is 1 exactly when the interrupt bit of at least one channel is 1.
- R10: The address map is as follows. Address bit 3 selects the channel. Offset 0 is the command register, offset 2 the status register and offset 4 the pointer register. Every other offset reads 0 and ignores writes. Read data appears on `rd_data` with `rd_valid` one cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, right-aligned |
| dma_start | output | 2 | Start pulse, one bit per channel |
| dma_abort | output | 2 | Abort pulse, one bit per channel |
| dma_ptr | output | 64 | Descriptor pointer of each channel, channel 0 in the low 32 bits |
| dma_done | input | 2 | Transfer-complete pulse, one bit per channel |
| irq | output | 1 | Interrupt request |
| size_err | output | 1 | Sticky flag for a write of illegal size |

## Verification
Every result of a write, including the register contents, the start and abort pulses, `irq` and `size_err`, is due on the first clock edge that takes the write. The bench samples these results 1 ns after that edge, so a pulse is seen during the single cycle it lasts. Read data is registered and so is due on the edge that takes the read. Each read therefore gets its own cycle, which starts after the preceding write or completion pulse has been taken. The bench computes every expected value from the requirement bit positions and sweeps both channels with the same sequence.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_W     = 8;
    localparam int OFF_W     = 3;

    localparam logic [OFF_W-1:0] OFF_CMD = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STS = 3'd2;
    localparam logic [OFF_W-1:0] OFF_PTR = 3'd4;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;
    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_INT = 2;

    localparam logic [REG_W-1:0] STS_RESET = 8'h60;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CMD  = 2'd1,
        RG_STS  = 2'd2,
        RG_PTR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr_en;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } chan_wr_t;

    function automatic reg_sel_e decode_off(logic [OFF_W-1:0] off);
        case (off)
            OFF_CMD: return RG_CMD;
            OFF_STS: return RG_STS;
            OFF_PTR: return RG_PTR;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic logic size_legal(reg_sel_e sel, logic [1:0] sz);
        case (sel)
            RG_CMD, RG_STS: return sz == SZ_BYTE;
            RG_PTR:         return sz == SZ_WORD;
            default:        return 1'b1;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] cmd_merge(logic [REG_W-1:0] old_v,
                                                   logic [REG_W-1:0] wr_v);
        logic [REG_W-1:0] r;
        r = wr_v;
        if (old_v[CMD_RUN])
            r[CMD_DIR] = old_v[CMD_DIR];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] sts_merge(logic [REG_W-1:0] old_v,
                                                   logic [REG_W-1:0] wr_v);
        logic [REG_W-1:0] r;
        r          = wr_v;
        r[STS_ACT] = old_v[STS_ACT];
        r[STS_ERR] = old_v[STS_ERR] & ~wr_v[STS_ERR];
        r[STS_INT] = old_v[STS_INT] & ~wr_v[STS_INT];
        return r;
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output chan_wr_t          ch_wr [NUM_CH],
    output reg_sel_e          rd_sel,
    output logic              bad_size
);
    localparam int CH_W = ADDR_W - OFF_W;

    logic [CH_W-1:0] ch_idx;
    reg_sel_e        sel;
    logic            legal;
    logic            in_range;

    always_comb begin
        ch_idx   = req_addr[ADDR_W-1:OFF_W];
        in_range = int'(ch_idx) < NUM_CH;
        sel      = in_range ? decode_off(req_addr[OFF_W-1:0]) : RG_NONE;
        legal    = size_legal(sel, req_size);
        bad_size = req_valid && req_write && (sel != RG_NONE) && !legal;
        rd_sel   = sel;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        always_comb begin
            ch_wr[i].wr_en = req_valid && req_write && (sel != RG_NONE) && legal
                             && (int'(ch_idx) == i);
            ch_wr[i].sel   = sel;
            ch_wr[i].data  = req_wdata;
        end
    end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_wr_t          wr,
    input  logic              done,
    output logic [REG_W-1:0]  cmd_q,
    output logic [REG_W-1:0]  sts_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic              start_p,
    output logic              abort_p
);
    logic [REG_W-1:0]  cmd_d, sts_d;
    logic [DATA_W-1:0] ptr_d;
    logic              start_d, abort_d;

    always_comb begin
        cmd_d   = cmd_q;
        sts_d   = sts_q;
        ptr_d   = ptr_q;
        start_d = 1'b0;
        abort_d = 1'b0;
        if (wr.wr_en) begin
            case (wr.sel)
                RG_CMD: begin
                    cmd_d = cmd_merge(cmd_q, wr.data[REG_W-1:0]);
                    if (!cmd_q[CMD_RUN] && cmd_d[CMD_RUN]) begin
                        sts_d[STS_ACT] = 1'b1;
                        start_d        = 1'b1;
                    end else if (cmd_q[CMD_RUN] && !cmd_d[CMD_RUN]) begin
                        sts_d[STS_ACT] = 1'b0;
                        abort_d        = 1'b1;
                    end
                end
                RG_STS:  sts_d = sts_merge(sts_q, wr.data[REG_W-1:0]);
                RG_PTR:  ptr_d = {wr.data[DATA_W-1:2], 2'b00};
                default: ;
            endcase
        end
        if (done) begin
            cmd_d[CMD_RUN] = 1'b0;
            sts_d[STS_ACT] = 1'b0;
            sts_d[STS_INT] = 1'b1;
            start_d        = 1'b0;
            abort_d        = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            sts_q   <= STS_RESET;
            ptr_q   <= '0;
            start_p <= 1'b0;
            abort_p <= 1'b0;
        end else begin
            cmd_q   <= cmd_d;
            sts_q   <= sts_d;
            ptr_q   <= ptr_d;
            start_p <= start_d;
            abort_p <= abort_d;
        end
    end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH) + OFF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_CH-1:0]        dma_start,
    output logic [NUM_CH-1:0]        dma_abort,
    output logic [NUM_CH*DATA_W-1:0] dma_ptr,
    input  logic [NUM_CH-1:0]        dma_done,
    output logic                     irq,
    output logic                     size_err
);
    localparam int CH_W = ADDR_W - OFF_W;

    chan_wr_t          ch_wr [NUM_CH];
    reg_sel_e          rd_sel;
    logic              bad_size;
    logic [REG_W-1:0]  cmd_a [NUM_CH];
    logic [REG_W-1:0]  sts_a [NUM_CH];
    logic [DATA_W-1:0] ptr_a [NUM_CH];
    logic [NUM_CH*REG_W-1:0] cmd_flat, sts_flat;
    logic [NUM_CH-1:0] int_bits;
    logic [DATA_W-1:0] rd_next;
    logic [CH_W-1:0]   rd_ch;

    bmdma_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .ch_wr     (ch_wr),
        .rd_sel    (rd_sel),
        .bad_size  (bad_size)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        bmdma_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr      (ch_wr[i]),
            .done    (dma_done[i]),
            .cmd_q   (cmd_a[i]),
            .sts_q   (sts_a[i]),
            .ptr_q   (ptr_a[i]),
            .start_p (dma_start[i]),
            .abort_p (dma_abort[i])
        );
        assign dma_ptr[i*DATA_W +: DATA_W] = ptr_a[i];
        assign cmd_flat[i*REG_W +: REG_W]  = cmd_a[i];
        assign sts_flat[i*REG_W +: REG_W]  = sts_a[i];
        assign int_bits[i]                 = sts_a[i][STS_INT];
    end

    assign irq   = |int_bits;
    assign rd_ch = req_addr[ADDR_W-1:OFF_W];

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(rd_ch) == i) begin
                case (rd_sel)
                    RG_CMD:  rd_next = {{(DATA_W-REG_W){1'b0}}, cmd_a[i]};
                    RG_STS:  rd_next = {{(DATA_W-REG_W){1'b0}}, sts_a[i]};
                    RG_PTR:  rd_next = ptr_a[i];
                    default: rd_next = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            size_err <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rd_data <= rd_next;
            if (bad_size)
                size_err <= 1'b1;
        end
    end

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
    parameter int NUM_CH = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_CH-1:0]     dma_start,
    input logic [NUM_CH-1:0]     dma_abort,
    input logic [NUM_CH-1:0]     dma_done,
    input logic [NUM_CH*32-1:0]  dma_ptr,
    input logic [NUM_CH*8-1:0]   cmd_flat,
    input logic [NUM_CH*8-1:0]   sts_flat,
    input logic                  irq,
    input logic                  size_err
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
        // R2
        start_active_chk: assert property (@(posedge clk) disable iff (rst)
            dma_start[i] |-> (sts_flat[i*8] && cmd_flat[i*8]));
        // R3
        abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
            dma_abort[i] |-> (!sts_flat[i*8] && !cmd_flat[i*8]));
        // R4
        dir_frozen_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(cmd_flat[i*8]) && cmd_flat[i*8]) |-> $stable(cmd_flat[i*8+3]));
        // R7
        done_effect_chk: assert property (@(posedge clk) disable iff (rst)
            dma_done[i] |=> (sts_flat[i*8+2] && !cmd_flat[i*8] && !sts_flat[i*8]));
        // R8
        ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
            dma_ptr[i*32 +: 2] == 2'b00);
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        size_err |=> size_err);
    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|dma_done));

endmodule

bind bmdma_regs bmdma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_start (dma_start),
    .dma_abort (dma_abort),
    .dma_done  (dma_done),
    .dma_ptr   (dma_ptr),
    .cmd_flat  (cmd_flat),
    .sts_flat  (sts_flat),
    .irq       (irq),
    .size_err  (size_err)
);

// File: tb/sim_bmdma_regs.sv
`timescale 1ns/1ps
module sim_bmdma_regs;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  dma_start, dma_abort, dma_done = '0;
    logic [63:0] dma_ptr;
    logic        irq, size_err;

    int nvec = 0, nerr = 0;
    logic [1:0]  st_seen, ab_seen;
    logic [31:0] rv;

    always #2 clk = ~clk;

    bmdma_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dma_start(dma_start),
        .dma_abort(dma_abort), .dma_ptr(dma_ptr), .dma_done(dma_done),
        .irq(irq), .size_err(size_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk); #1;
        st_seen = dma_start; ab_seen = dma_abort;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 2'd2;
        @(posedge clk); #1;
        rv = rd_valid ? rd_data : 32'hxxxx_xxxx;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic done_pulse(input logic [1:0] m);
        @(negedge clk); dma_done = m;
        @(posedge clk); #1;
        @(negedge clk); dma_done = '0;
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin : main
        logic [31:0] pv;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 size_err", {31'd0, size_err}, 32'd0);

        for (int ch = 0; ch < NCH; ch++) begin
            logic [3:0] b;
            b = 4'(ch * 8);
            rd(b);      chk("R1 cmd reset", rv, 32'h00);
            rd(b + 2);  chk("R1 sts reset", rv, 32'h60);
            rd(b + 4);  chk("R1 ptr reset", rv, 32'h0);
            wr(b + 1, 2'd0, 32'hAA);
            rd(b + 1);  chk("R10 unmapped read", rv, 32'h0);
            rd(b);      chk("R10 unmapped write ignored", rv, 32'h00);

            pv = '0;
            for (int k = 0; k < 4; k++) begin
                pv = (32'h1357_9BDF * (k + 1)) ^ (32'(ch) << 20) ^ 32'(k);
                wr(b + 4, 2'd2, pv);
                rd(b + 4); chk("R8 ptr low bits zero", rv, pv & 32'hFFFF_FFFC);
            end
            pv = pv & 32'hFFFF_FFFC;

            wr(b, 2'd0, 32'h01);
            chk("R2 start pulse", {30'd0, st_seen}, 32'(1 << ch));
            chk("R2 ptr with start", dma_ptr[ch*32 +: 32], pv);
            rd(b + 2);  chk("R2 active set", rv, 32'h61);
            wr(b, 2'd0, 32'h09);
            chk("R3 no pulse on same run", {30'd0, st_seen | ab_seen}, 32'd0);
            rd(b);      chk("R4 dir frozen while running", rv, 32'h01);

            wr(b + 2, 2'd0, 32'hFE);
            rd(b + 2);  chk("R5 active ro, upper bits rw", rv, 32'hF9);
            wr(b + 2, 2'd0, 32'h00);
            rd(b + 2);  chk("R5 upper bits cleared, active kept", rv, 32'h01);

            done_pulse(2'(1 << ch));
            rd(b);      chk("R7 done clears run", rv, 32'h00);
            rd(b + 2);  chk("R7 done sets int clears active", rv, 32'h04);
            chk("R9 irq on", {31'd0, irq}, 32'd1);
            wr(b + 2, 2'd0, 32'h00);
            rd(b + 2);  chk("R6 write zero keeps int", rv, 32'h04);
            wr(b + 2, 2'd0, 32'h06);
            rd(b + 2);  chk("R6 write one clears int", rv, 32'h00);
            chk("R9 irq off", {31'd0, irq}, 32'd0);

            wr(b, 2'd0, 32'h09);
            chk("R2 restart pulse", {30'd0, st_seen}, 32'(1 << ch));
            wr(b, 2'd0, 32'h00);
            chk("R3 abort pulse", {30'd0, ab_seen}, 32'(1 << ch));
            rd(b);      chk("R4 dir kept on stopping write", rv, 32'h08);
            rd(b + 2);  chk("R3 active cleared", rv, 32'h00);
            wr(b, 2'd0, 32'h00);
            chk("R3 no pulse when stopped", {30'd0, ab_seen | st_seen}, 32'd0);
            rd(b);      chk("R4 dir free when stopped", rv, 32'h00);

            wr(b, 2'd2, 32'h01);
            chk("R8 bad size no start", {30'd0, st_seen}, 32'd0);
            chk("R8 size_err set", {31'd0, size_err}, 32'd1);
            rd(b);      chk("R8 bad size cmd ignored", rv, 32'h00);
            wr(b + 4, 2'd0, 32'hFF);
            rd(b + 4);  chk("R8 bad size ptr ignored", rv, pv);
        end

        done_pulse(2'b11);
        chk("R9 both int", {31'd0, irq}, 32'd1);
        wr(4'd2, 2'd0, 32'h04);
        chk("R9 one remaining", {31'd0, irq}, 32'd1);
        wr(4'd10, 2'd0, 32'h04);
        chk("R9 none remaining", {31'd0, irq}, 32'd0);
        chk("R8 size_err sticky", {31'd0, size_err}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule